// File: doc/BRIEF.md
# Dual-Rail Pulsed Two-Input Logic Unit

This block is one quarter of a fine-grained reconfigurable cell, modelled as a clocked circuit. Each of its two operands arrives as a one-cycle pulse on one of two wires: one wire means zero and the other means one. There is no separate request wire, because a pulse on either wire is the request. A static 4-bit truth table selects any of the sixteen two-input Boolean functions. The result leaves on a dual-rail pair of output wires as a one-cycle pulse, and its value stays in an output register.

The two operands may arrive in the same cycle or in different cycles. Each operand is held until its partner turns up. The unit then evaluates and clears its holding latches, so a new pair can follow at once. If one operand pulses on both of its wires, that is an encoding violation: the pair is thrown away and a sticky error flag is raised.

A join gate sits beside the unit. It takes the ready flags of the neighbouring quarters, combines them with this quarter's own ready flag under a selection mask, and emits a one-cycle completion pulse. This pulse merges several parallel computations back into one.

Top module: `dr_logic_unit`

## Requirements
- R1: Operand A is carried on wires `aZero`/`aOne` and operand B on `bZero`/`bOne`. A one-cycle high pulse on exactly one wire of a pair delivers that operand, and its value is 1 when the pulse is on the one-wire.
- R2: The result is `funcTable[{a,b}]`, with A as the index MSB. So bit 0 covers input 00, bit 1 covers 01, bit 2 covers 10 and bit 3 covers 11. `funcTable = 4'b1000` gives AND, and all 16 tables are legal.
- R3: Exactly one result pulse is emitted per completed pair. It is one cycle wide, it appears only on the wire matching the result value (`resOne` for 1, `resZero` for 0), and it is visible in the cycle after the clock edge that captures the second operand. The two output wires are never high together.
- R4: An operand that arrives first is held until the other one arrives. A repeated pulse on the same wire of an operand that is already held has no effect, so only one result pulse follows.
- R5: `resultBit` takes the result value at the edge that launches the result pulse, and keeps it until the next result.
- R6: The holding latches are cleared when the result is launched. Operand pulses that arrive in that same cycle start the next pair, so pairs delivered on consecutive cycles give result pulses on consecutive cycles.
- R7: A conflict occurs when both wires of one operand pulse in the same cycle, or when an operand pulses on the wire opposite to its held value. A conflict discards every held and arriving operand, produces no result pulse, and sets `errFlag`. `errFlag` stays set until reset.
- R8: `readyOwn` goes high together with the result pulse. It returns low at the first later clock edge that sees an operand pulse.
- R9: The join gate forms a ready vector. Bit 0 of that vector is `readyOwn` and bit i is `peerReady[i-1]`. When the vector covers every bit set in `joinMask`, and the mask is not zero, `joinFire` pulses for one cycle in the cycle after the condition first becomes true. A zero mask never fires.
- R10: A synchronous active-high reset clears the holding latches, both result wires, `resultBit`, `readyOwn`, `errFlag` and `joinFire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| funcTable | input | 4 | Truth table, indexed by {a,b} |
| aZero | input | 1 | Operand A zero-wire pulse |
| aOne | input | 1 | Operand A one-wire pulse |
| bZero | input | 1 | Operand B zero-wire pulse |
| bOne | input | 1 | Operand B one-wire pulse |
| peerReady | input | NUM_QUARTERS-1 | Ready flags of the other quarters |
| joinMask | input | NUM_QUARTERS | Quarters taking part in the join, bit 0 is this quarter |
| resZero | output | 1 | Result zero-wire pulse |
| resOne | output | 1 | Result one-wire pulse |
| resultBit | output | 1 | Registered result value |
| readyOwn | output | 1 | This quarter holds a fresh result |
| errFlag | output | 1 | Sticky dual-rail encoding violation |
| joinFire | output | 1 | Join completion pulse |

## Verification
The bench builds the unit with the default `NUM_QUARTERS = 4`. This gives a three-bit peer vector and a four-bit mask, which is small enough that random masks regularly land on the all-ready, partially-ready and zero-mask cases of the join. Having the table fixed at four entries lets the bench sweep all sixteen functions over all four operand pairs. Random operand arrival (same cycle or split, in random order) then covers the holding path, and directed sequences cover back-to-back pairs, duplicate pulses and both kinds of conflict.

// File: rtl/dr_lu_pkg.sv
package dr_lu_pkg;
  localparam int NUM_OPS = 2;

  typedef struct packed {
    logic               launch;
    logic               flush;
    logic [NUM_OPS-1:0] take;
  } luStrobe_t;
endpackage

// File: rtl/dr_lu_ctrl.sv
module dr_lu_ctrl
  import dr_lu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] railZero,
  input  logic [NUM_OPS-1:0] railOne,
  input  logic [NUM_OPS-1:0] held,
  input  logic [NUM_OPS-1:0] heldVal,
  output luStrobe_t          strobe,
  output logic               readyOwn,
  output logic               errFlag
);
  logic                evalNow;
  logic [NUM_OPS-1:0]  heldEff;
  logic [NUM_OPS-1:0]  conflictOp;
  logic                conflict;
  logic                anyPulse;

  assign evalNow = &held;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : gSlot
      assign heldEff[gi]    = held[gi] & ~evalNow;
      assign conflictOp[gi] = (railZero[gi] & railOne[gi]) |
                              (heldEff[gi] & ((heldVal[gi] & railZero[gi]) |
                                              (~heldVal[gi] & railOne[gi])));
      assign strobe.take[gi] = ~conflict & (railZero[gi] | railOne[gi]) & ~heldEff[gi];
    end
  endgenerate

  assign conflict      = |conflictOp;
  assign anyPulse      = |(railZero | railOne);
  assign strobe.launch = evalNow;
  assign strobe.flush  = evalNow | conflict;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyOwn <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strobe.launch)  readyOwn <= 1'b1;
      else if (anyPulse)  readyOwn <= 1'b0;
      if (conflict)       errFlag  <= 1'b1;
    end
  end

  // R7: the error flag never drops outside reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R7: the error flag only rises after an operand pulse
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> $past(|(railZero | railOne)));
endmodule

// File: rtl/dr_lu_datapath.sv
module dr_lu_datapath
  import dr_lu_pkg::*;
#(
  parameter int TABLE_SIZE = 1 << NUM_OPS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_OPS-1:0]    railOne,
  input  logic [TABLE_SIZE-1:0] funcTable,
  input  luStrobe_t             strobe,
  output logic [NUM_OPS-1:0]    held,
  output logic [NUM_OPS-1:0]    heldVal,
  output logic                  resZero,
  output logic                  resOne,
  output logic                  resultBit
);
  logic tableOut;

  assign tableOut = funcTable[heldVal];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : gLatch
      always_ff @(posedge clk) begin
        if (rst) begin
          held[gi]    <= 1'b0;
          heldVal[gi] <= 1'b0;
        end else if (strobe.take[gi]) begin
          held[gi]    <= 1'b1;
          heldVal[gi] <= railOne[gi];
        end else if (strobe.flush) begin
          held[gi]    <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resZero   <= 1'b0;
      resOne    <= 1'b0;
      resultBit <= 1'b0;
    end else begin
      resOne  <= strobe.launch & tableOut;
      resZero <= strobe.launch & ~tableOut;
      if (strobe.launch) resultBit <= tableOut;
    end
  end

  // R3: the output wires are never high together
  assert_rail_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resZero, resOne}));

  // R3: a result pulse needs a complete operand pair one edge earlier
  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (resZero | resOne) |-> $past(&held));

  // R5: the stored result matches the pulse just emitted
  assert_hold_result_R5: assert property (@(posedge clk) disable iff (rst)
    (resZero | resOne) |-> (resultBit == resOne));
endmodule

// File: rtl/dr_lu_join.sv
module dr_lu_join #(
  parameter int NUM_QUARTERS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_QUARTERS-1:0] readyVec,
  input  logic [NUM_QUARTERS-1:0] joinMask,
  output logic                    joinFire
);
  logic allReady;
  logic allReadyPrev;

  assign allReady = (|joinMask) && ((readyVec & joinMask) == joinMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      allReadyPrev <= 1'b0;
      joinFire     <= 1'b0;
    end else begin
      allReadyPrev <= allReady;
      joinFire     <= allReady & ~allReadyPrev;
    end
  end

  // R9: the join pulse is one cycle wide
  assert_join_single_R9: assert property (@(posedge clk) disable iff (rst)
    joinFire |=> !joinFire);

  // R9: an empty mask never produces a join pulse
  assert_join_mask_R9: assert property (@(posedge clk) disable iff (rst)
    joinFire |-> $past(|joinMask));
endmodule

// File: rtl/dr_logic_unit.sv
module dr_logic_unit
  import dr_lu_pkg::*;
#(
  parameter int NUM_QUARTERS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              funcTable,
  input  logic                    aZero,
  input  logic                    aOne,
  input  logic                    bZero,
  input  logic                    bOne,
  input  logic [NUM_QUARTERS-2:0] peerReady,
  input  logic [NUM_QUARTERS-1:0] joinMask,
  output logic                    resZero,
  output logic                    resOne,
  output logic                    resultBit,
  output logic                    readyOwn,
  output logic                    errFlag,
  output logic                    joinFire
);
  localparam int TABLE_SIZE = 1 << NUM_OPS;

  luStrobe_t          strobe;
  logic [NUM_OPS-1:0] railZero;
  logic [NUM_OPS-1:0] railOne;
  logic [NUM_OPS-1:0] held;
  logic [NUM_OPS-1:0] heldVal;

  // slot 1 is operand A so that the held values index the table as {a,b}
  assign railZero = {aZero, bZero};
  assign railOne  = {aOne, bOne};

  dr_lu_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .railZero (railZero),
    .railOne  (railOne),
    .held     (held),
    .heldVal  (heldVal),
    .strobe   (strobe),
    .readyOwn (readyOwn),
    .errFlag  (errFlag)
  );

  dr_lu_datapath #(.TABLE_SIZE(TABLE_SIZE)) uDp (
    .clk       (clk),
    .rst       (rst),
    .railOne   (railOne),
    .funcTable (funcTable),
    .strobe    (strobe),
    .held      (held),
    .heldVal   (heldVal),
    .resZero   (resZero),
    .resOne    (resOne),
    .resultBit (resultBit)
  );

  dr_lu_join #(.NUM_QUARTERS(NUM_QUARTERS)) uJoin (
    .clk      (clk),
    .rst      (rst),
    .readyVec ({peerReady, readyOwn}),
    .joinMask (joinMask),
    .joinFire (joinFire)
  );

  // R8: ready is up whenever a result pulse is out
  assert_ready_with_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (resZero | resOne) |-> readyOwn);
endmodule

// File: tb/dr_logic_unit_test.sv
`timescale 1ns/1ps
module dr_logic_unit_test;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    funcTable = 4'b0000;
  logic          aZero = 1'b0, aOne = 1'b0, bZero = 1'b0, bOne = 1'b0;
  logic [NQ-2:0] peerReady = '0;
  logic [NQ-1:0] joinMask = '0;
  logic          resZero, resOne, resultBit, readyOwn, errFlag, joinFire;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dr_logic_unit #(.NUM_QUARTERS(NQ)) uut (
    .clk(clk), .rst(rst), .funcTable(funcTable),
    .aZero(aZero), .aOne(aOne), .bZero(bZero), .bOne(bOne),
    .peerReady(peerReady), .joinMask(joinMask),
    .resZero(resZero), .resOne(resOne), .resultBit(resultBit),
    .readyOwn(readyOwn), .errFlag(errFlag), .joinFire(joinFire)
  );

  function automatic bit expResult(logic [3:0] tbl, bit a, bit b);
    return tbl[{a, b}];
  endfunction

  function automatic bit expJoin(logic [NQ-1:0] m, logic [NQ-2:0] p, bit own);
    logic [NQ-1:0] v;
    v = {p, own};
    return (m != 0) && ((v & m) == m);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle pulse on the chosen wires; returns at the negedge after capture
  task automatic drive(bit az, bit ao, bit bz, bit bo);
    aZero = az; aOne = ao; bZero = bz; bOne = bo;
    tick();
    aZero = 0; aOne = 0; bZero = 0; bOne = 0;
  endtask

  task automatic runOp(logic [3:0] tbl, bit a, bit b, int split);
    bit e;
    e = expResult(tbl, a, b);
    funcTable = tbl;
    if (split == 1) begin
      drive(!a, a, 0, 0);
      chk("R4 held, no early pulse", resZero | resOne, 0);
      drive(0, 0, !b, b);
    end else if (split == 2) begin
      drive(0, 0, !b, b);
      tick();
      chk("R4 held over gap", resZero | resOne, 0);
      drive(!a, a, 0, 0);
    end else begin
      drive(!a, a, !b, b);
    end
    chk("R3 no pulse at capture edge", resZero | resOne, 0);
    tick();
    chk("R2 resOne", resOne, e);
    chk("R3 resZero", resZero, !e);
    tick();
    chk("R3 pulse one cycle", resZero | resOne, 0);
    chk("R5 resultBit", resultBit, e);
    chk("R8 ready", readyOwn, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R10 resZero reset", resZero, 0);
    chk("R10 resOne reset", resOne, 0);
    chk("R10 resultBit reset", resultBit, 0);
    chk("R10 ready reset", readyOwn, 0);
    chk("R10 err reset", errFlag, 0);
    chk("R10 join reset", joinFire, 0);
    rst = 1'b0;
    tick();

    // R2: AND table, then every table over every pair
    runOp(4'b1000, 1, 1, 0);
    runOp(4'b1000, 1, 0, 0);
    for (int t = 0; t < 16; t++)
      for (int k = 0; k < 4; k++)
        runOp(t[3:0], k[1], k[0], 0);

    // R1/R4: random arrival order
    for (int n = 0; n < 100; n++)
      runOp(4'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3));

    // R4: duplicate pulse on a held operand
    funcTable = 4'b1000;
    drive(0, 1, 0, 0);
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 1);
    tick();
    chk("R4 single pulse after duplicate", resOne, 1);
    tick();
    chk("R4 no second pulse", resZero | resOne, 0);
    tick();
    chk("R4 still no second pulse", resZero | resOne, 0);

    // R6: back-to-back pairs, XOR table
    funcTable = 4'b0110;
    aOne = 1; bZero = 1;                 // op1: 1^0 = 1
    @(posedge clk); @(negedge clk);
    aOne = 1; bZero = 0; bOne = 1;       // op2: 1^1 = 0, arrives with launch
    @(posedge clk); @(negedge clk);
    aOne = 0; bOne = 0;
    chk("R6 first pulse", resOne, 1);
    tick();
    chk("R6 second pulse zero wire", resZero, 1);
    chk("R6 second pulse one wire", resOne, 0);
    tick();
    chk("R6 quiet after pair", resZero | resOne, 0);

    // R7: both wires of A in one cycle
    drive(1, 1, 0, 1);
    chk("R7 err set", errFlag, 1);
    chk("R8 ready cleared by conflict", readyOwn, 0);
    tick();
    chk("R7 no pulse after conflict", resZero | resOne, 0);
    tick();
    chk("R7 no late pulse", resZero | resOne, 0);
    drive(0, 0, 0, 1);                   // B alone: earlier operands were discarded
    tick(); tick();
    chk("R7 pair discarded", resZero | resOne, 0);
    drive(1, 0, 0, 0);                   // A=0, B=1 -> xor 1
    tick();
    chk("R7 fresh pair works", resOne, 1);
    tick();

    // R7: opposite wire on a held operand
    drive(0, 1, 0, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    tick(); tick();
    chk("R7 opposite wire discards", resZero | resOne, 0);
    drive(1, 0, 0, 0);                   // 0^0 = 0
    tick();
    chk("R7 after opposite wire", resZero, 1);
    tick();
    chk("R7 err sticky", errFlag, 1);

    // R9: random masks with own ready high
    for (int n = 0; n < 24; n++) begin
      logic [NQ-1:0] m;
      logic [NQ-2:0] p;
      m = NQ'($urandom);
      p = (NQ-1)'($urandom);
      joinMask = m; peerReady = p;
      tick();
      chk("R9 join fire", joinFire, expJoin(m, p, 1));
      tick();
      chk("R9 join one cycle", joinFire, 0);
      joinMask = '0;
      tick();
    end

    // R9/R8: join waits for own ready
    drive(0, 1, 0, 0);
    joinMask = '1; peerReady = '1;
    tick();
    chk("R9 no fire without own ready", joinFire, 0);
    drive(0, 0, 0, 1);
    chk("R9 wait capture", joinFire, 0);
    tick();
    chk("R9 wait launch", joinFire, 0);
    tick();
    chk("R9 fire after own ready", joinFire, 1);
    tick();
    chk("R9 fire drops", joinFire, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule